// File: doc/BRIEF.md
# LPC clock-stop request gating

This block follows the state of the PCI clock that feeds the LPC peripherals, as those peripherals see it, and qualifies their DMA request inputs against that state. A request line carries meaning only while the remote device is clocked. Sampling it at other times would misread a level that the device cannot update. The block therefore models every host clock edge as either reaching the peripheral or not. It latches requests only on edges that reach the peripheral, and it drives the qualified request flags to zero while the peripheral clock is stopped.

The timing model is exact to the edge. When the stop-clock control is first seen high, the peripheral still receives that one edge and then nothing more. When the control is seen low again, the first host edge still does not reach the peripheral, and the second one is the peripheral's first edge. A running counter of the peripheral edges and a clock-running status are exported so that the edge accounting can be observed. The block also merges clock-run requests. A peripheral may ask for the clock directly, and the block raises the clock-run line on behalf of any channel whose peripheral is running DMA or bus-master cycles.

Top module: `lpc_clkstop_gate`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `clk_on_o`=1, `edge_cnt_o`=0, `req_held_o`=0, `req_valid_o`=0 and `clkrun_o`=0.
- R2: If the clock is running (`clk_on_o`=1) and `stop_clk_i` is sampled high at an edge, that edge is the last one the peripheral sees. `edge_cnt_o` goes up by one, `req_held_o` and `req_valid_o` take `req_i`, and `clk_on_o` reads 0 in the next cycle.
- R3: At every edge after the stop edge and before restart, the peripheral sees no edge. `edge_cnt_o` and `req_held_o` keep their values whatever `req_i` does, and `req_valid_o` is 0.
- R4: If the clock is stopped and `stop_clk_i` is sampled low at edge k, edge k still reaches no peripheral and `clk_on_o` stays 0. Edge k+1 is the first peripheral edge: `edge_cnt_o` goes up by one, the requests are re-sampled from `req_i`, and `clk_on_o` reads 1 afterwards unless the stop condition of R7 applies.
- R5: While the clock is running, every host edge is a peripheral edge. `edge_cnt_o` goes up by one modulo 2^CNT_W, and bit i of `req_held_o` and of `req_valid_o` follows `req_i[i]` with one cycle of latency, independently per channel.
- R6: `clkrun_o` is 1 in the cycle after an edge at which `clkrun_req_i` is high or any bit of `dma_busy_i` is high, and 0 after any other edge.
- R7: If `stop_clk_i` is sampled high at the first peripheral edge of a restart (edge k+1 of R4), that edge still counts and samples the requests, and the clock returns to stopped (`clk_on_o`=0).
- R8: `req_valid_o[i]` is never 1 while `req_held_o[i]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host PCI clock |
| rst | input | 1 | Synchronous reset, active high |
| stop_clk_i | input | 1 | Stop-clock control for the peripheral clock, 1 = stop |
| clkrun_req_i | input | 1 | Clock-run request driven by a peripheral |
| dma_busy_i | input | NUM_CH | Per channel: peripheral is running DMA or bus-master cycles |
| req_i | input | NUM_CH | Per-channel DMA request inputs from the peripherals |
| clkrun_o | output | 1 | Merged clock-run request, registered |
| clk_on_o | output | 1 | Peripheral clock running status, registered |
| edge_cnt_o | output | CNT_W | Count of edges the peripheral has seen, wraps |
| req_held_o | output | NUM_CH | Last request value sampled on a peripheral edge |
| req_valid_o | output | NUM_CH | Qualified request valid flags |

## Verification
All outputs are registered. Each result becomes visible one cycle after the edge that samples its cause. The exception is a restart, where the count and the re-sampled requests move only after the second edge following the release of `stop_clk_i`. The bench keeps a behavioural model that advances on the same rising edge as the design, and it compares every output on the following falling edge. Each comparison is tagged with the requirement that the model's state at that edge exercises. Directed sequences cover the single-cycle stop pulse, a stop that arrives during the restart edge, the wrap of the counter and a mid-run reset. A long randomized run follows them.

// File: rtl/lpc_clkstop_pkg.sv
`timescale 1ns/1ps
package lpc_clkstop_pkg;

  // Peripheral clock as seen from the remote side.
  //   PCLK_RUN  : every host edge reaches the peripheral
  //   PCLK_STOP : no host edge reaches the peripheral
  //   PCLK_WAKE : release seen; the coming edge is the first one delivered
  typedef enum logic [1:0] {
    PCLK_RUN  = 2'd0,
    PCLK_STOP = 2'd1,
    PCLK_WAKE = 2'd2
  } pclk_state_e;

endpackage

// File: rtl/lpc_pclk_tracker.sv
`timescale 1ns/1ps
module lpc_pclk_tracker
  import lpc_clkstop_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stop_clk_i,
  output logic             periph_edge_o,
  output logic             clk_on_o,
  output logic [CNT_W-1:0] edge_cnt_o,
  output pclk_state_e      state_o
);

  pclk_state_e st_q;
  pclk_state_e st_d;

  // The current host edge reaches the peripheral unless the clock is fully
  // stopped: the edge that samples a fresh stop still gets through, and the
  // edge after a release does too (the one right at the release does not).
  always_comb begin
    periph_edge_o = (st_q != PCLK_STOP);
    unique case (st_q)
      PCLK_STOP: st_d = stop_clk_i ? PCLK_STOP : PCLK_WAKE;
      default:   st_d = stop_clk_i ? PCLK_STOP : PCLK_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= PCLK_RUN;
      clk_on_o   <= 1'b1;
      edge_cnt_o <= '0;
    end else begin
      st_q     <= st_d;
      clk_on_o <= (st_d == PCLK_RUN);
      if (periph_edge_o) begin
        edge_cnt_o <= edge_cnt_o + CNT_W'(1);
      end
    end
  end

  assign state_o = st_q;

endmodule

// File: rtl/lpc_req_qualifier.sv
`timescale 1ns/1ps
module lpc_req_qualifier #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              periph_edge_i,
  input  logic [NUM_CH-1:0] req_i,
  output logic [NUM_CH-1:0] held_o,
  output logic [NUM_CH-1:0] valid_o
);

  // One latch pair per channel; a request is only sampled on an edge the
  // peripheral actually receives, and is held untouched otherwise.
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic held_q;
    logic valid_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        held_q  <= 1'b0;
        valid_q <= 1'b0;
      end else if (periph_edge_i) begin
        held_q  <= req_i[g];
        valid_q <= req_i[g];
      end else begin
        valid_q <= 1'b0;
      end
    end

    assign held_o[g]  = held_q;
    assign valid_o[g] = valid_q;
  end

endmodule

// File: rtl/lpc_clkrun_merge.sv
`timescale 1ns/1ps
module lpc_clkrun_merge #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clkrun_req_i,
  input  logic [NUM_CH-1:0] dma_busy_i,
  output logic              clkrun_o
);

  // Channels running DMA or bus-master cycles get the clock-run line
  // raised for them, next to any direct peripheral request.
  always_ff @(posedge clk) begin
    if (rst) begin
      clkrun_o <= 1'b0;
    end else begin
      clkrun_o <= clkrun_req_i | (|dma_busy_i);
    end
  end

endmodule

// File: rtl/lpc_clkstop_gate.sv
`timescale 1ns/1ps
module lpc_clkstop_gate
  import lpc_clkstop_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stop_clk_i,
  input  logic              clkrun_req_i,
  input  logic [NUM_CH-1:0] dma_busy_i,
  input  logic [NUM_CH-1:0] req_i,
  output logic              clkrun_o,
  output logic              clk_on_o,
  output logic [CNT_W-1:0]  edge_cnt_o,
  output logic [NUM_CH-1:0] req_held_o,
  output logic [NUM_CH-1:0] req_valid_o
);

  logic        periph_edge;
  pclk_state_e trk_state;

  lpc_pclk_tracker #(
    .CNT_W(CNT_W)
  ) u_tracker (
    .clk          (clk),
    .rst          (rst),
    .stop_clk_i   (stop_clk_i),
    .periph_edge_o(periph_edge),
    .clk_on_o     (clk_on_o),
    .edge_cnt_o   (edge_cnt_o),
    .state_o      (trk_state)
  );

  lpc_req_qualifier #(
    .NUM_CH(NUM_CH)
  ) u_qualifier (
    .clk          (clk),
    .rst          (rst),
    .periph_edge_i(periph_edge),
    .req_i        (req_i),
    .held_o       (req_held_o),
    .valid_o      (req_valid_o)
  );

  lpc_clkrun_merge #(
    .NUM_CH(NUM_CH)
  ) u_clkrun (
    .clk         (clk),
    .rst         (rst),
    .clkrun_req_i(clkrun_req_i),
    .dma_busy_i  (dma_busy_i),
    .clkrun_o    (clkrun_o)
  );

endmodule

// File: rtl/lpc_clkstop_gate_chk.sv
`timescale 1ns/1ps
module lpc_clkstop_gate_chk
  import lpc_clkstop_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              stop_clk_i,
  input logic              clkrun_req_i,
  input logic [NUM_CH-1:0] dma_busy_i,
  input logic              clkrun_o,
  input logic              clk_on_o,
  input logic [CNT_W-1:0]  edge_cnt_o,
  input logic [NUM_CH-1:0] req_held_o,
  input logic [NUM_CH-1:0] req_valid_o,
  input pclk_state_e       st_i
);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (clk_on_o && edge_cnt_o == '0 && req_held_o == '0 &&
             req_valid_o == '0 && !clkrun_o));

  assert_stop_last_edge_R2: assert property (@(posedge clk) disable iff (rst)
    (clk_on_o && stop_clk_i) |=>
      (!clk_on_o && (edge_cnt_o - $past(edge_cnt_o)) == CNT_W'(1)));

  assert_stopped_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    $stable(edge_cnt_o) |-> (req_valid_o == '0 && $stable(req_held_o)));

  assert_release_gap_R4: assert property (@(posedge clk) disable iff (rst)
    (st_i == PCLK_STOP && !stop_clk_i) |=> ($stable(edge_cnt_o) && !clk_on_o));

  assert_first_edge_R4: assert property (@(posedge clk) disable iff (rst)
    (st_i == PCLK_WAKE) |=> ((edge_cnt_o - $past(edge_cnt_o)) == CNT_W'(1)));

  assert_run_count_R5: assert property (@(posedge clk) disable iff (rst)
    clk_on_o |=> ((edge_cnt_o - $past(edge_cnt_o)) == CNT_W'(1)));

  assert_clkrun_on_R6: assert property (@(posedge clk) disable iff (rst)
    (clkrun_req_i || (|dma_busy_i)) |=> clkrun_o);

  assert_clkrun_off_R6: assert property (@(posedge clk) disable iff (rst)
    !(clkrun_req_i || (|dma_busy_i)) |=> !clkrun_o);

  assert_wake_restop_R7: assert property (@(posedge clk) disable iff (rst)
    (st_i == PCLK_WAKE && stop_clk_i) |=> (!clk_on_o && st_i == PCLK_STOP));

  assert_valid_needs_held_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid_o & ~req_held_o) == '0);

endmodule

bind lpc_clkstop_gate lpc_clkstop_gate_chk #(
  .NUM_CH(NUM_CH),
  .CNT_W (CNT_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .stop_clk_i  (stop_clk_i),
  .clkrun_req_i(clkrun_req_i),
  .dma_busy_i  (dma_busy_i),
  .clkrun_o    (clkrun_o),
  .clk_on_o    (clk_on_o),
  .edge_cnt_o  (edge_cnt_o),
  .req_held_o  (req_held_o),
  .req_valid_o (req_valid_o),
  .st_i        (trk_state)
);

// File: tb/lpc_clkstop_gate_tb.sv
`timescale 1ns/1ps
module lpc_clkstop_gate_tb;

  localparam int NUM_CH = 4;
  localparam int CNT_W  = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              stop_clk = 1'b0;
  logic              clkrun_req = 1'b0;
  logic [NUM_CH-1:0] dma_busy = '0;
  logic [NUM_CH-1:0] req = '0;
  logic              clkrun_o;
  logic              clk_on_o;
  logic [CNT_W-1:0]  edge_cnt_o;
  logic [NUM_CH-1:0] req_held_o;
  logic [NUM_CH-1:0] req_valid_o;

  always #2.5 clk = ~clk;

  lpc_clkstop_gate #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .stop_clk_i(stop_clk), .clkrun_req_i(clkrun_req),
    .dma_busy_i(dma_busy), .req_i(req), .clkrun_o(clkrun_o),
    .clk_on_o(clk_on_o), .edge_cnt_o(edge_cnt_o),
    .req_held_o(req_held_o), .req_valid_o(req_valid_o)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // Reference model: 0 = running, 1 = stopped, 2 = release seen
  int                m_state  = 0;
  int                m_cnt    = 0;
  logic [NUM_CH-1:0] m_held   = '0;
  logic [NUM_CH-1:0] m_valid  = '0;
  bit                m_on     = 1'b1;
  bit                m_clkrun = 1'b0;
  bit                m_live   = 1'b0;
  string             m_tag    = "R1";

  always @(posedge clk) begin
    bit pe;
    m_live = 1'b1;
    if (rst) begin
      m_state = 0; m_cnt = 0; m_held = '0; m_valid = '0;
      m_on = 1'b1; m_clkrun = 1'b0; m_tag = "R1";
    end else begin
      pe = (m_state != 1);
      case (m_state)
        0:       m_tag = stop_clk ? "R2" : "R5";
        1:       m_tag = stop_clk ? "R3" : "R4";
        default: m_tag = stop_clk ? "R7" : "R4";
      endcase
      if (pe) begin
        m_cnt   = (m_cnt + 1) % (1 << CNT_W);
        m_held  = req;
        m_valid = req;
      end else begin
        m_valid = '0;
      end
      if (m_state == 1) m_state = stop_clk ? 1 : 2;
      else              m_state = stop_clk ? 1 : 0;
      m_on     = (m_state == 0);
      m_clkrun = clkrun_req || (|dma_busy);
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (m_live && !done) begin
      chk(m_tag, "clk_on_o", int'(clk_on_o), int'(m_on));
      chk(m_tag, "edge_cnt_o", int'(edge_cnt_o), m_cnt);
      chk(m_tag, "req_held_o", int'(req_held_o), int'(m_held));
      chk(m_tag, "req_valid_o", int'(req_valid_o), int'(m_valid));
      chk((m_tag == "R1") ? "R1" : "R6", "clkrun_o", int'(clkrun_o), int'(m_clkrun));
      // R8: qualified flag never without a held request
      chk("R8", "valid_without_held", int'(req_valid_o & ~req_held_o), 0);
    end
  end

  task automatic cycles(int n, bit rnd_req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rnd_req) req = NUM_CH'($urandom);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R5: running with changing requests
    cycles(12, 1'b1);
    // R2 / R3: stop held for several cycles, requests keep moving
    @(negedge clk); stop_clk = 1'b1; req = 4'b1010;
    cycles(8, 1'b1);
    // R4: release
    @(negedge clk); stop_clk = 1'b0;
    cycles(6, 1'b1);
    // single-cycle stop pulse
    @(negedge clk); stop_clk = 1'b1;
    @(negedge clk); stop_clk = 1'b0;
    cycles(5, 1'b1);
    // R7: stop returns exactly on the first edge after a release
    @(negedge clk); stop_clk = 1'b1;
    cycles(4, 1'b1);
    @(negedge clk); stop_clk = 1'b0;
    @(negedge clk); stop_clk = 1'b1; req = 4'b0110;
    cycles(3, 1'b1);
    @(negedge clk); stop_clk = 1'b0;
    cycles(4, 1'b1);
    // R6: clock-run sources
    @(negedge clk); clkrun_req = 1'b1;
    cycles(2, 1'b0);
    @(negedge clk); clkrun_req = 1'b0; dma_busy = 4'b0100;
    cycles(3, 1'b0);
    @(negedge clk); dma_busy = '0;
    cycles(2, 1'b0);
    // R5: counter wrap
    cycles(300, 1'b1);
    // R1: reset in the middle of a stop
    @(negedge clk); stop_clk = 1'b1;
    cycles(3, 1'b1);
    @(negedge clk); rst = 1'b1;
    cycles(3, 1'b1);
    @(negedge clk); rst = 1'b0; stop_clk = 1'b0;
    // randomized mix
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      req        = NUM_CH'($urandom);
      clkrun_req = ($urandom % 5) == 0;
      dma_busy   = (($urandom % 4) == 0) ? NUM_CH'($urandom) : '0;
      if (($urandom % 6) == 0) stop_clk = ~stop_clk;
    end
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule